// File: doc/BRIEF.md
# Shared-Address Mode Register Pair

This block holds two 8-bit serial-channel mode registers that software reaches through one bus address. A hidden pointer picks which of the two an access lands on. After reset the pointer selects the first register. Any access to the first register, whether a read or a write, moves the pointer to the second register. The pointer then stays on the second register until a set-pointer command returns it.

The host side is a simple synchronous register port: a select, read and write strobes, and a byte in each direction. A separate command input carries the 3-bit miscellaneous code from the channel's command register. The first register is split into named configuration fields for the serial channel logic. The second register is passed on as a whole byte.

Top module: `mode_reg_pair`

## Requirements
- R1: After reset the pointer selects register 1. Register 1 holds 0x20 and register 2 holds 0x00.
- R2: An access to register 1 moves the pointer to register 2 for the next cycle. An access is `regSel` high together with `rdStb` or `wrStb`, and a read counts the same as a write.
- R3: Accesses to register 2 leave the pointer on register 2.
- R4: `cmdValid` high with `cmdMisc` equal to 3'b001 returns the pointer to register 1 for the next cycle. Any other `cmdMisc` value leaves the pointer unchanged.
- R5: When a set-pointer command and an access happen in the same cycle, the access still reaches the register selected before that edge, and the pointer then selects register 1.
- R6: Bit 5 of register 1 always reads as 1, whatever value is written to it.
- R7: Readback is combinational. During a read access, `rdData` shows the selected register. It is 0x00 in any cycle without a read access. A written value appears on the register and field outputs from the following cycle.
- R8: Strobes with `regSel` low neither write a register nor move the pointer.
- R9: The register 1 fields map as follows: bit 7 `rxRtsEn`, bit 6 `rxIrqSel`, bit 5 `errMode`, bits 4:3 `parityMode`, bit 2 `parityType`, bits 1:0 `bitsPerChar`. Register 2 appears whole on `mr2Cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 1 | Address decode hit for the shared mode address |
| rdStb | input | 1 | Read strobe |
| wrStb | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid during the read cycle |
| cmdValid | input | 1 | Command register write strobe |
| cmdMisc | input | 3 | Miscellaneous command code; 3'b001 resets the pointer |
| rxRtsEn | output | 1 | Receiver flow-control enable |
| rxIrqSel | output | 1 | Receiver interrupt source select |
| errMode | output | 1 | Error reporting mode, fixed to 1 |
| parityMode | output | 2 | Parity mode |
| parityType | output | 1 | Parity type or address/data flag |
| bitsPerChar | output | 2 | Data bits per character code |
| mr2Cfg | output | 8 | Register 2 contents |

## Verification
The pointer cannot be seen at the ports, so every claim about it has to be inferred from which register the next read returns. The two registers are therefore loaded with clearly different values (0xA5 in register 2, a value with bit 5 set in register 1) before the pointer tests begin. The hardest case is a set-pointer command that lands in the same cycle as an access. The stimulus sets this up twice, once with a read while the pointer is on register 2 and once with a write while it is on register 1. The following read then shows both where the access went and where the pointer ended up.

// File: rtl/mode_reg_pkg.sv
package mode_reg_pkg;
  localparam int DATA_W = 8;
  localparam int MISC_W = 3;
  localparam logic [MISC_W-1:0] SET_PTR_CODE = 3'b001;
  localparam int FIXED_BIT = 5;
  localparam logic [DATA_W-1:0] MR1_RESET = 8'h00;
  localparam logic [DATA_W-1:0] MR2_RESET = 8'h00;

  typedef enum logic {PTR_MR1 = 1'b0, PTR_MR2 = 1'b1} ptr_e;

  typedef struct packed {
    logic wrMr1;
    logic wrMr2;
    logic rdEn;
    logic rdMr2;
  } strobe_t;
endpackage

// File: rtl/mode_reg_ctrl.sv
module mode_reg_ctrl
  import mode_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic              cmdValid,
  input  logic [MISC_W-1:0] cmdMisc,
  output strobe_t           stb
);
  ptr_e ptrQ, ptrD;
  logic access, setPtr;

  assign access = regSel && (rdStb || wrStb);
  assign setPtr = cmdValid && (cmdMisc == SET_PTR_CODE);

  always_comb begin
    ptrD = ptrQ;
    if (setPtr)       ptrD = PTR_MR1;
    else if (access)  ptrD = PTR_MR2;
  end

  always_ff @(posedge clk) begin
    if (!rstN) ptrQ <= PTR_MR1;
    else       ptrQ <= ptrD;
  end

  always_comb begin
    stb.wrMr1 = regSel && wrStb && (ptrQ == PTR_MR1);
    stb.wrMr2 = regSel && wrStb && (ptrQ == PTR_MR2);
    stb.rdEn  = regSel && rdStb;
    stb.rdMr2 = (ptrQ == PTR_MR2);
  end

  // R2: register 1 access advances pointer
  a_r2_mr1_access_moves: assert property (@(posedge clk) disable iff (!rstN)
    (access && ptrQ == PTR_MR1 && !setPtr) |=> ptrQ == PTR_MR2);
  // R3: register 2 access keeps pointer
  a_r3_mr2_access_stays: assert property (@(posedge clk) disable iff (!rstN)
    (access && ptrQ == PTR_MR2 && !setPtr) |=> ptrQ == PTR_MR2);
  // R4/R5: command wins and returns pointer
  a_r4_cmd_returns: assert property (@(posedge clk) disable iff (!rstN)
    setPtr |=> ptrQ == PTR_MR1);
  // R8: no access, no command, pointer holds
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!access && !setPtr) |=> $stable(ptrQ));
  a_r5_single_write: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrMr1 && stb.wrMr2));
endmodule

// File: rtl/mode_reg_data.sv
module mode_reg_data
  import mode_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] mr1Q,
  output logic [DATA_W-1:0] mr2Q
);
  localparam logic [DATA_W-1:0] FIXED_MASK = DATA_W'(1) << FIXED_BIT;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mr1Q <= MR1_RESET | FIXED_MASK;
      mr2Q <= MR2_RESET;
    end else begin
      if (stb.wrMr1) mr1Q <= wrData | FIXED_MASK;
      if (stb.wrMr2) mr2Q <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    if (stb.rdEn) rdData = stb.rdMr2 ? mr2Q : mr1Q;
  end

  // R6: fixed bit stays set
  a_r6_fixed_bit: assert property (@(posedge clk) disable iff (!rstN)
    mr1Q[FIXED_BIT]);
  // R7: writes land next cycle
  a_r7_wr_mr2: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrMr2 |=> mr2Q == $past(wrData));
  a_r7_wr_mr1_other_bits: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrMr1 |=> (mr1Q & ~FIXED_MASK) == ($past(wrData) & ~FIXED_MASK));
  a_r7_no_write_mr2: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrMr2 |=> $stable(mr2Q));
endmodule

// File: rtl/mode_reg_pair.sv
module mode_reg_pair
  import mode_reg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regSel,
  input  logic       rdStb,
  input  logic       wrStb,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       cmdValid,
  input  logic [2:0] cmdMisc,
  output logic       rxRtsEn,
  output logic       rxIrqSel,
  output logic       errMode,
  output logic [1:0] parityMode,
  output logic       parityType,
  output logic [1:0] bitsPerChar,
  output logic [7:0] mr2Cfg
);
  strobe_t stb;
  logic [DATA_W-1:0] mr1Q, mr2Q;

  mode_reg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .rdStb(rdStb), .wrStb(wrStb),
    .cmdValid(cmdValid), .cmdMisc(cmdMisc), .stb(stb)
  );

  mode_reg_data u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .rdData(rdData), .mr1Q(mr1Q), .mr2Q(mr2Q)
  );

  // R9: field split of register 1
  assign rxRtsEn     = mr1Q[7];
  assign rxIrqSel    = mr1Q[6];
  assign errMode     = mr1Q[5];
  assign parityMode  = mr1Q[4:3];
  assign parityType  = mr1Q[2];
  assign bitsPerChar = mr1Q[1:0];
  assign mr2Cfg      = mr2Q;
endmodule

// File: tb/test_mode_reg_pair.sv
module test_mode_reg_pair;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regSel = 1'b0, rdStb = 1'b0, wrStb = 1'b0, cmdValid = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [2:0] cmdMisc = 3'b000;
  logic [7:0] rdData, mr2Cfg;
  logic rxRtsEn, rxIrqSel, errMode, parityType;
  logic [1:0] parityMode, bitsPerChar;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mode_reg_pair i_mode_reg_pair (
    .clk(clk), .rstN(rstN), .regSel(regSel), .rdStb(rdStb), .wrStb(wrStb),
    .wrData(wrData), .rdData(rdData), .cmdValid(cmdValid), .cmdMisc(cmdMisc),
    .rxRtsEn(rxRtsEn), .rxIrqSel(rxIrqSel), .errMode(errMode),
    .parityMode(parityMode), .parityType(parityType),
    .bitsPerChar(bitsPerChar), .mr2Cfg(mr2Cfg)
  );

  // {sel, rd, wr, cmd, misc[2:0], wdata[7:0], expRd[7:0]}
  localparam int NV = 14;
  localparam logic [22:0] VEC [NV] = '{
    {4'b1100, 3'd0, 8'h00, 8'h20}, // R1 R2 read reg1 after reset
    {4'b1100, 3'd0, 8'h00, 8'h00}, // R1 R2 now reg2
    {4'b1010, 3'd0, 8'hA5, 8'h00}, // R7 write reg2
    {4'b1100, 3'd0, 8'h00, 8'hA5}, // R3 R7 still reg2
    {4'b0001, 3'd1, 8'h00, 8'h00}, // R4 set pointer
    {4'b1010, 3'd0, 8'h5A, 8'h00}, // R6 write reg1
    {4'b1100, 3'd0, 8'h00, 8'hA5}, // R2 moved to reg2
    {4'b0001, 3'd1, 8'h00, 8'h00}, // R4 set pointer
    {4'b0001, 3'd3, 8'h00, 8'h00}, // R4 other code ignored
    {4'b0110, 3'd0, 8'hFF, 8'h00}, // R8 strobes without select
    {4'b1100, 3'd0, 8'h00, 8'h7A}, // R4 R6 R8 still reg1, unchanged
    {4'b1101, 3'd1, 8'h00, 8'hA5}, // R5 read reg2 with command
    {4'b1011, 3'd1, 8'h00, 8'h00}, // R5 write reg1 with command
    {4'b1100, 3'd0, 8'h00, 8'h20}  // R5 R6 pointer stayed on reg1
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic s, input logic r, input logic w,
                        input logic [7:0] d, input logic c, input logic [2:0] m);
    regSel = s; rdStb = r; wrStb = w; wrData = d; cmdValid = c; cmdMisc = m;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 reg1 reset via errMode", {7'd0, errMode}, 8'h01);
    chk("R1 reg2 reset", mr2Cfg, 8'h00);
    chk("R1 rdData idle", rdData, 8'h00);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      access(VEC[i][22], VEC[i][21], VEC[i][20], VEC[i][15:8], VEC[i][19], VEC[i][18:16]);
      #1;
      chk($sformatf("R2-R8 vector %0d", i), rdData, VEC[i][7:0]);
    end
    @(negedge clk); access(0, 0, 0, 8'h00, 0, 3'd0);
    #1;
    chk("R5 reg1 written with command", {rxRtsEn, rxIrqSel, errMode, parityMode, parityType, bitsPerChar}, 8'h20);
    // pointer is on reg2 now
    @(negedge clk); access(1, 0, 1, 8'h3C, 0, 3'd0);
    @(negedge clk); access(0, 0, 0, 8'h00, 1, 3'd1);
    #1;
    chk("R7 R9 mr2Cfg", mr2Cfg, 8'h3C);
    @(negedge clk); access(1, 0, 1, 8'h9B, 0, 3'd0);
    @(negedge clk); access(0, 0, 0, 8'h00, 0, 3'd0);
    #1;
    chk("R9 rxRtsEn", {7'd0, rxRtsEn}, 8'h01);
    chk("R9 rxIrqSel", {7'd0, rxIrqSel}, 8'h00);
    chk("R6 R9 errMode", {7'd0, errMode}, 8'h01);
    chk("R9 parityMode", {6'd0, parityMode}, 8'h03);
    chk("R9 parityType", {7'd0, parityType}, 8'h00);
    chk("R9 bitsPerChar", {6'd0, bitsPerChar}, 8'h03);
    // mid-run reset
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    #1;
    chk("R1 reset clears reg2", mr2Cfg, 8'h00);
    chk("R1 reset clears reg1", {rxRtsEn, rxIrqSel, errMode, parityMode, parityType, bitsPerChar}, 8'h20);
    access(1, 1, 0, 8'h00, 0, 3'd0);
    #1;
    chk("R1 pointer back on reg1", rdData, 8'h20);
    @(negedge clk); access(0, 0, 0, 8'h00, 0, 3'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule